// File: doc/BRIEF.md
# Boot ROM Bus Slave Read Sequencer

This block is the slave-side controller for a boot-loader ROM on a system bus where reads are strobed asynchronously. While the bus master holds its active-low strobe, the block compares the upper address bits against a fixed boot address. On a hit it raises a match output and starts a paced timing chain. A five-stage shift register is stepped by a slow phase tick. When the last stage is reached, the next tick is passed to the ROM as a single read strobe. The trailing edge of that strobe raises a data-valid flag. After a fixed delay, a fixed-width completion pulse is driven back toward the bus.

The strobe, the address and an external initialise line pass through two-flop synchronizers before any decision is made. Each strobe allows one read only: once a sequence has started, further matches are ignored until the strobe is released. Releasing the strobe clears the match and every piece of sequencing state. A falling edge on the initialise line drops the run flags, which stalls a sequence that has not yet read. A two-bit configuration input picks which one of four active-low ROM bank enables is driven low.

Top module: `bootrom_slave_seq`

## Requirements
- R1: The match output goes high on the third clock after the strobe goes low with the upper address equal to BOOT_ADDR. It never goes high for any other address.
- R2: Within three clocks of strobe release, the match, data-valid and completion outputs are all low.
- R3: The read strobe rises between START_W+2+5*TICK_DIV and START_W+1+6*TICK_DIV clocks after the match output rises. Any two read strobes rise a whole multiple of TICK_DIV clocks apart, because they follow the free-running phase tick.
- R4: The read strobe is high for exactly one clock.
- R5: The data-valid output rises on the clock after the read strobe rises, which is the strobe's trailing edge. It stays high until the strobe is released.
- R6: The completion output rises DONE_DLY clocks after data-valid rises. It stays high for exactly DONE_LEN clocks and occurs once per strobe.
- R7: While the strobe is still held after completion, no further read strobe or completion pulse is produced.
- R8: A falling edge on the initialise input while the chain runs, before the read, prevents any read strobe for the rest of that strobe.
- R9: The bank enable output has bit number equal to the configuration value low and the other three bits high. It follows the configuration input without a clock.
- R10: After reset, with the strobe inactive, the match, read, data-valid and completion outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz intended) |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_strb_n | input | 1 | Active-low bus strobe, asynchronous |
| bus_addr_hi | input | ADDR_W | Upper bus address bits, asynchronous |
| init_n | input | 1 | External initialise; falling edge clears run flags |
| bank_cfg | input | 2 | Selects the ROM bank enable |
| addr_match | output | 1 | Boot address recognised under active strobe |
| rom_rd | output | 1 | One-clock ROM read strobe |
| data_vld | output | 1 | ROM data valid flag |
| bus_done | output | 1 | Completion pulse toward the bus |
| bank_en_n | output | 4 | Active-low ROM bank enables, exactly one low |

## Verification
The bench builds the block with TICK_DIV=16, START_W=8, DONE_DLY=5, DONE_LEN=5, an 8-bit address and a boot address of 0xC3. These are the intended defaults. With them a full read completes in about 120 clocks, so one strobe window of 260 clocks covers the whole chain and also a long idle tail after completion. That tail is where re-triggering would show. Because the tick period is short, the unknown tick phase at each match produces read latencies across the whole R3 window over a few dozen transactions. Directed strobes with an initialise pulse and with near-miss addresses are mixed in.

// File: rtl/bootrom_pkg.sv
package bootrom_pkg;

    typedef enum logic [1:0] {
        DN_IDLE  = 2'd0,
        DN_WAIT  = 2'd1,
        DN_PULSE = 2'd2,
        DN_SPENT = 2'd3
    } done_st_e;

endpackage

// File: rtl/bootrom_sync.sv
module bootrom_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/bootrom_tick.sv
module bootrom_tick #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == TW'(DIV - 1)) cnt_d = '0;
        else                       cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == TW'(DIV - 1));
endmodule

// File: rtl/bootrom_bank_dec.sv
module bootrom_bank_dec (
    input  logic [1:0] cfg_i,
    output logic [3:0] en_n_o
);
    always_comb begin
        for (int i = 0; i < 4; i++) begin
            en_n_o[i] = (cfg_i != 2'(i));
        end
    end

    // R9: exactly one bank enable active
    always_comb begin
        a_r9_one_bank: assert ($countones(en_n_o) == 3 || $isunknown(cfg_i));
    end
endmodule

// File: rtl/bootrom_seq_core.sv
module bootrom_seq_core
    import bootrom_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BOOT_ADDR = 8'hC3,
    parameter int              CHAIN     = 5,
    parameter int              START_W   = 8,
    parameter int              DONE_DLY  = 5,
    parameter int              DONE_LEN  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strb_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              init_fall_i,
    input  logic              tick_i,
    output logic              match_o,
    output logic              rd_o,
    output logic              vld_o,
    output logic              done_o
);
    localparam int SCNT_W = $clog2(START_W + 1);
    localparam int DMAX   = (DONE_DLY > DONE_LEN) ? DONE_DLY : DONE_LEN;
    localparam int DCNT_W = $clog2(DMAX + 1);

    typedef struct packed {
        logic              match;
        logic              armed;
        logic              start;
        logic [SCNT_W-1:0] scnt;
        logic              run;
        logic              go;
        logic [CHAIN-1:0]  stage;
        logic              rd;
        logic              vld;
        done_st_e          dst;
        logic [DCNT_W-1:0] dcnt;
    } seq_t;

    seq_t n_d, q_q;

    always_comb begin
        n_d       = q_q;
        n_d.match = strb_i && (addr_i == BOOT_ADDR);
        n_d.rd    = 1'b0;

        // launch: start pulse into first stage
        if (q_q.match && !q_q.armed) begin
            n_d.armed = 1'b1;
            n_d.start = 1'b1;
            n_d.scnt  = SCNT_W'(START_W - 1);
            n_d.stage = CHAIN'(1);
        end

        // trailing edge of start pulse sets run flag
        if (q_q.start) begin
            if (q_q.scnt == '0) begin
                n_d.start = 1'b0;
                n_d.run   = 1'b1;
            end else begin
                n_d.scnt = q_q.scnt - SCNT_W'(1);
            end
        end

        // first tick after run enables stepping
        if (q_q.run && !q_q.go && tick_i) n_d.go = 1'b1;

        // stepping and read strobe
        if (q_q.go && tick_i) begin
            if (!q_q.stage[CHAIN-1]) n_d.stage = q_q.stage << 1;
            else if (!q_q.vld && !q_q.rd) n_d.rd = 1'b1;
        end

        // trailing edge of read sets data valid
        if (q_q.rd) n_d.vld = 1'b1;

        // completion delay and pulse
        case (q_q.dst)
            DN_IDLE: if (q_q.rd) begin
                n_d.dst  = DN_WAIT;
                n_d.dcnt = DCNT_W'(DONE_DLY - 1);
            end
            DN_WAIT: if (q_q.dcnt == '0) begin
                n_d.dst  = DN_PULSE;
                n_d.dcnt = DCNT_W'(DONE_LEN - 1);
            end else begin
                n_d.dcnt = q_q.dcnt - DCNT_W'(1);
            end
            DN_PULSE: if (q_q.dcnt == '0) begin
                n_d.dst = DN_SPENT;
            end else begin
                n_d.dcnt = q_q.dcnt - DCNT_W'(1);
            end
            default: n_d.dst = q_q.dst;
        endcase

        // external initialise edge clears run flags
        if (init_fall_i) begin
            n_d.start = 1'b0;
            n_d.run   = 1'b0;
            n_d.go    = 1'b0;
        end

        // strobe release clears the sequence
        if (!strb_i) begin
            n_d.armed = 1'b0;
            n_d.start = 1'b0;
            n_d.scnt  = '0;
            n_d.run   = 1'b0;
            n_d.go    = 1'b0;
            n_d.stage = '0;
            n_d.rd    = 1'b0;
            n_d.vld   = 1'b0;
            n_d.dst   = DN_IDLE;
            n_d.dcnt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '{match: 1'b0, armed: 1'b0, start: 1'b0, scnt: '0,
                     run: 1'b0, go: 1'b0, stage: '0, rd: 1'b0, vld: 1'b0,
                     dst: DN_IDLE, dcnt: '0};
        end else begin
            q_q <= n_d;
        end
    end

    assign match_o = q_q.match;
    assign rd_o    = q_q.rd;
    assign vld_o   = q_q.vld;
    assign done_o  = (q_q.dst == DN_PULSE);

    // R4: read strobe lasts one clock
    a_r4_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.rd |=> !q_q.rd);

    // R3: read only from the final stage under a live match
    a_r3_rd_final_stage: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.rd |-> (q_q.stage[CHAIN-1] && q_q.match));

    // R3: timing chain holds at most one active stage
    a_r3_stage_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_q.stage));

    // R5: data valid rises only after a read strobe
    a_r5_vld_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_q.vld) |-> $past(q_q.rd));

    // R6: completion only while data is valid
    a_r6_done_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> q_q.vld);

    // R2: release clears the sequence on the next clock
    a_r2_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_i |=> (!q_q.vld && !done_o && !q_q.go && !q_q.match));
endmodule

// File: rtl/bootrom_slave_seq.sv
module bootrom_slave_seq #(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BOOT_ADDR = 8'hC3,
    parameter int              TICK_DIV  = 16,
    parameter int              CHAIN     = 5,
    parameter int              START_W   = 8,
    parameter int              DONE_DLY  = 5,
    parameter int              DONE_LEN  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_strb_n,
    input  logic [ADDR_W-1:0] bus_addr_hi,
    input  logic              init_n,
    input  logic [1:0]        bank_cfg,
    output logic              addr_match,
    output logic              rom_rd,
    output logic              data_vld,
    output logic              bus_done,
    output logic [3:0]        bank_en_n
);
    localparam int SW = ADDR_W + 1;

    logic [SW-1:0]     sa_raw, sa_sync;
    logic              strb_s;
    logic [ADDR_W-1:0] addr_s;
    logic              init_s;
    logic              init_prev_d, init_prev_q;
    logic              init_fall;
    logic              tick;

    assign sa_raw = {bus_addr_hi, ~bus_strb_n};

    bootrom_sync #(.W(SW), .RST_VAL('0)) u_sync_bus (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (sa_raw),
        .q_o  (sa_sync)
    );

    assign strb_s = sa_sync[0];
    assign addr_s = sa_sync[SW-1:1];

    bootrom_sync #(.W(1), .RST_VAL(1'b1)) u_sync_init (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (init_n),
        .q_o  (init_s)
    );

    always_comb init_prev_d = init_s;

    always_ff @(posedge clk) begin
        if (!rst_n) init_prev_q <= 1'b1;
        else        init_prev_q <= init_prev_d;
    end

    assign init_fall = init_prev_q && !init_s;

    bootrom_tick #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_o(tick)
    );

    bootrom_seq_core #(
        .ADDR_W   (ADDR_W),
        .BOOT_ADDR(BOOT_ADDR),
        .CHAIN    (CHAIN),
        .START_W  (START_W),
        .DONE_DLY (DONE_DLY),
        .DONE_LEN (DONE_LEN)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .strb_i     (strb_s),
        .addr_i     (addr_s),
        .init_fall_i(init_fall),
        .tick_i     (tick),
        .match_o    (addr_match),
        .rd_o       (rom_rd),
        .vld_o      (data_vld),
        .done_o     (bus_done)
    );

    bootrom_bank_dec u_bank (
        .cfg_i (bank_cfg),
        .en_n_o(bank_en_n)
    );
endmodule

// File: tb/bootrom_slave_seq_test.sv
module bootrom_slave_seq_test;
    localparam int         ADDR_W   = 8;
    localparam logic [7:0] BOOT     = 8'hC3;
    localparam int         TICK_DIV = 16;
    localparam int         START_W  = 8;
    localparam int         DLY      = 5;
    localparam int         LEN      = 5;
    localparam int         HOLD     = 260;
    localparam int         RD_LO    = START_W + 2 + 5 * TICK_DIV;
    localparam int         RD_HI    = START_W + 1 + 6 * TICK_DIV;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_strb_n = 1'b1;
    logic [ADDR_W-1:0] bus_addr_hi = '0;
    logic             init_n = 1'b1;
    logic [1:0]       bank_cfg = 2'd0;
    logic             addr_match, rom_rd, data_vld, bus_done;
    logic [3:0]       bank_en_n;

    int checks = 0;
    int errors = 0;
    int gc = 0;
    int last_rd = -1;

    always #10 clk = ~clk;

    bootrom_slave_seq #(
        .ADDR_W(ADDR_W), .BOOT_ADDR(BOOT), .TICK_DIV(TICK_DIV), .CHAIN(5),
        .START_W(START_W), .DONE_DLY(DLY), .DONE_LEN(LEN)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bus_strb_n(bus_strb_n),
        .bus_addr_hi(bus_addr_hi), .init_n(init_n), .bank_cfg(bank_cfg),
        .addr_match(addr_match), .rom_rd(rom_rd), .data_vld(data_vld),
        .bus_done(bus_done), .bank_en_n(bank_en_n)
    );

    function automatic logic [3:0] exp_bank(input logic [1:0] c);
        return ~(4'b0001 << c);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        gc++;
    endtask

    task automatic run_txn(input logic [7:0] a, input logic [1:0] cfg, input bit do_init);
        int match_at = -1, rd_at = -1, rd_cnt = 0, rd_w = 0, vld_at = -1;
        int done_at = -1, done_cnt = 0, done_w = 0, post_rd = 0;
        bit hit;
        hit = (a == BOOT);
        bank_cfg = cfg;
        #1;
        chk(bank_en_n == exp_bank(cfg), "R9 bank enable", int'(bank_en_n), int'(exp_bank(cfg)));
        bus_addr_hi = a;
        bus_strb_n  = 1'b0;
        for (int c = 1; c <= HOLD; c++) begin
            logic prd, pdn;
            prd = rom_rd;
            pdn = bus_done;
            if (do_init && c == 30) init_n = 1'b0;
            if (do_init && c == 32) init_n = 1'b1;
            step();
            if (addr_match && match_at < 0) match_at = c;
            if (rom_rd) rd_w++;
            if (rom_rd && !prd) begin
                rd_cnt++;
                if (rd_at < 0) rd_at = c;
                if (last_rd >= 0)
                    chk(((gc - last_rd) % TICK_DIV) == 0, "R3 tick alignment", gc - last_rd, TICK_DIV);
                last_rd = gc;
            end
            if (data_vld && vld_at < 0) vld_at = c;
            if (bus_done) done_w++;
            if (bus_done && !pdn) begin
                done_cnt++;
                if (done_at < 0) done_at = c;
            end
            if (rd_at >= 0 && c > rd_at + DLY + LEN + 2 && rom_rd) post_rd++;
        end
        if (hit) begin
            chk(match_at == 3, "R1 match latency", match_at, 3);
            if (do_init) begin
                chk(rd_cnt == 0, "R8 read suppressed by init", rd_cnt, 0);
                chk(data_vld == 1'b0, "R8 no data valid", int'(data_vld), 0);
            end else begin
                chk(rd_at - match_at >= RD_LO && rd_at - match_at <= RD_HI,
                    "R3 read latency", rd_at - match_at, RD_LO);
                chk(rd_w == 1, "R4 read width", rd_w, 1);
                chk(vld_at == rd_at + 1, "R5 data valid timing", vld_at, rd_at + 1);
                chk(data_vld == 1'b1, "R5 data valid held", int'(data_vld), 1);
                chk(done_at == vld_at + DLY, "R6 done delay", done_at, vld_at + DLY);
                chk(done_w == LEN && done_cnt == 1, "R6 done width", done_w, LEN);
                chk(rd_cnt == 1 && post_rd == 0, "R7 single read per strobe", rd_cnt, 1);
            end
        end else begin
            chk(match_at < 0, "R1 no match on other address", match_at, -1);
            chk(rd_cnt == 0 && vld_at < 0, "R1 no read on other address", rd_cnt, 0);
        end
        bus_strb_n = 1'b1;
        step(); step(); step();
        chk(!addr_match && !data_vld && !bus_done, "R2 release clears",
            int'({addr_match, data_vld, bus_done}), 0);
        for (int i = 0; i < 4; i++) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 4; i++) step();
        rst_n = 1'b1;
        step();
        chk(!addr_match && !rom_rd && !data_vld && !bus_done, "R10 reset state",
            int'({addr_match, rom_rd, data_vld, bus_done}), 0);
        // directed corners
        run_txn(BOOT, 2'd0, 1'b0);
        run_txn(BOOT ^ 8'h01, 2'd3, 1'b0);
        run_txn(BOOT ^ 8'h80, 2'd1, 1'b0);
        run_txn(BOOT, 2'd2, 1'b1);
        run_txn(BOOT, 2'd3, 1'b0);
        // random mix
        for (int t = 0; t < 30; t++) begin
            logic [7:0] a;
            logic [1:0] cfg;
            bit ini;
            cfg = 2'($urandom_range(0, 3));
            ini = ($urandom_range(0, 4) == 0);
            if ($urandom_range(0, 1) == 1) a = BOOT;
            else begin
                a = 8'($urandom_range(0, 255));
                if (a == BOOT) a = a ^ 8'h10;
            end
            for (int g = 0; g < int'($urandom_range(0, 20)); g++) step();
            run_txn(a, cfg, ini);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule